// File: doc/BRIEF.md
# Board control register file

This block is the control and status register file of an evaluation board. A processor reaches it through a simple single-beat 32-bit read/write bus. Only the low 20 bits of the byte address are decoded, so the register set repeats every 1 MB across the bus address space. Write effects take hold at the clock edge that accepts the request. Read data arrives one cycle after the request, with a valid strobe.

The block holds a byte that drives an 8-LED bar and an 8-character ASCII display buffer. Software can load the buffer in one write, where a 32-bit value becomes eight uppercase hexadecimal characters. It can also overwrite single characters through a row of per-position registers spaced 8 bytes apart. The block also issues a one-cycle software reset request and holds a general-purpose output byte. For a bit-banged two-wire serial bus it provides output enables, a clock/data output latch with a write strobe, an input readback and a device select bit. A read of an unmapped offset returns zero. An access to an unmapped offset raises a one-cycle error flag.

Top module: `board_ctrl_regs`

Register offsets (address bits [19:0]):

| Offset | Function |
|---|---|
| 0x00200 | Switch register, read only |
| 0x00408 | LED byte |
| 0x00410 | Hex word |
| 0x00418 + 8·k, k = 0..7 | Character k |
| 0x00500 | Software reset, write only |
| 0x00A00 | General-purpose output |
| 0x00B00 | Two-wire input, read only |
| 0x00B08 | Two-wire output enables |
| 0x00B10 | Two-wire output latch |
| 0x00B18 | Two-wire select |

## Requirements
- R1: Only bus_addr[19:0] select a register; bits [31:20] are ignored, so an access at 0xFFF00408 reaches the LED byte exactly like 0x00408.
- R2: The switch register at offset 0x00200 always reads 0x00000000 (every switch closed), and writes to it change nothing.
- R3: A write to offset 0x00408 stores wdata[7:0]; led_o[i] follows bit i, and the register reads back zero-extended. Without a write, led_o holds its value.
- R4: A write to offset 0x00410 replaces all eight characters. Character k becomes the uppercase ASCII hex digit of nibble wdata[31-4k:28-4k], so character 0 takes the most significant nibble. Digits 0-9 map to 0x30-0x39 and A-F map to 0x41-0x46. The offset reads back the last word written there. Character k appears on disp_o[8k+7:8k].
- R5: A write to offset 0x418 + 8·k (k = 0..7) stores wdata[7:0] as character k and leaves the other seven characters unchanged. A read of that offset returns the character zero-extended.
- R6: Any write to offset 0x00500 drives soft_rst_o high for exactly the one cycle after the accepting edge. A read of this offset returns zero.
- R7: Offset 0x00A00 keeps wdata[7:0] (gpio_o), offset 0x00B08 keeps wdata[1:0] (tw_oe_o) and offset 0x00B18 keeps wdata[0] (tw_sel_o). Each reads back zero-extended.
- R8: A write to offset 0x00B10 sets tw_scl_o from wdata[1] and tw_sda_o from wdata[0]. It also pulses tw_wr_o for one cycle to forward the write to the attached device. The offset reads back {scl, sda} in bits [1:0].
- R9: A read of offset 0x00B00 returns bit 1 equal to the last written clock level and bit 0 equal to tw_sda_i as sampled at the accepting edge. All other bits read zero.
- R10: After reset led_o is 0 and every character is 0x20 (space). The hex word, gpio_o, tw_oe_o and tw_sel_o are 0, and tw_scl_o and tw_sda_o are 1. No pulse is active.
- R11: An access to any other offset reads zero and changes no register. This includes offsets between character positions, such as 0x0041C, and 0x00458. The access pulses bus_err in the next cycle.
- R12: A read accepted at one edge yields bus_rvalid high and the data on bus_rdata for the following cycle. Otherwise bus_rvalid is 0 and bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request, accepted each cycle it is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Unmapped access flag, one cycle |
| led_o | output | 8 | LED bar levels |
| disp_o | output | 64 | Eight ASCII characters, character k in bits [8k+7:8k] |
| soft_rst_o | output | 1 | Software reset request pulse |
| gpio_o | output | 8 | General-purpose output byte |
| tw_oe_o | output | 2 | Two-wire output enables |
| tw_scl_o | output | 1 | Two-wire clock output level |
| tw_sda_o | output | 1 | Two-wire data output level |
| tw_wr_o | output | 1 | Output-latch write strobe to the device |
| tw_sel_o | output | 1 | Two-wire device select |
| tw_sda_i | input | 1 | Two-wire data line from the device |

## Verification
The bench builds the block with its default parameters: a 32-bit word, so eight characters, a character stride of 8 bytes and a 20-bit decode window. These values make the full hex conversion reachable. They also reach the last character slot at 0x450, the gap offsets between slots and the first offset past the row. With a 32-bit address, alias hits in the upper 12 bits can be exercised. A behavioural model tracks every output on every clock while directed and random accesses mix writes, reads and unmapped offsets.

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs #(
  parameter int ADDR_W      = 32,
  parameter int WIN_W       = 20,
  parameter int WORD_W      = 32,
  parameter int LED_W       = 8,
  parameter int GP_W        = 8,
  parameter int CHAR_STRIDE = 8,
  parameter logic [WIN_W-1:0] OFF_SWITCH  = 20'h00200,
  parameter logic [WIN_W-1:0] OFF_LED     = 20'h00408,
  parameter logic [WIN_W-1:0] OFF_HEX     = 20'h00410,
  parameter logic [WIN_W-1:0] OFF_CHAR0   = 20'h00418,
  parameter logic [WIN_W-1:0] OFF_SOFTRST = 20'h00500,
  parameter logic [WIN_W-1:0] OFF_GPIO    = 20'h00A00,
  parameter logic [WIN_W-1:0] OFF_TWIN    = 20'h00B00,
  parameter logic [WIN_W-1:0] OFF_TWOE    = 20'h00B08,
  parameter logic [WIN_W-1:0] OFF_TWOUT   = 20'h00B10,
  parameter logic [WIN_W-1:0] OFF_TWSEL   = 20'h00B18,
  localparam int NCH = WORD_W / 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  output logic [LED_W-1:0]  led_o,
  output logic [NCH*8-1:0]  disp_o,
  output logic              soft_rst_o,
  output logic [GP_W-1:0]   gpio_o,
  output logic [1:0]        tw_oe_o,
  output logic              tw_scl_o,
  output logic              tw_sda_o,
  output logic              tw_wr_o,
  output logic              tw_sel_o,
  input  logic              tw_sda_i
);

  localparam int SHIFT   = $clog2(CHAR_STRIDE);
  localparam int IDX_W   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CH_SPAN = NCH * CHAR_STRIDE;

  function automatic logic [7:0] hexc(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

  logic [WIN_W-1:0] off, char_rel;
  logic [IDX_W-1:0] char_idx;
  logic unused_hi;
  assign off       = bus_addr[WIN_W-1:0];
  assign unused_hi = ^bus_addr[ADDR_W-1:WIN_W];
  assign char_rel  = off - OFF_CHAR0;
  assign char_idx  = char_rel[SHIFT +: IDX_W];

  logic hit_sw, hit_led, hit_hex, hit_chr, hit_srst, hit_gp;
  logic hit_twin, hit_twoe, hit_twout, hit_twsel, hit_any;
  assign hit_sw    = off == OFF_SWITCH;
  assign hit_led   = off == OFF_LED;
  assign hit_hex   = off == OFF_HEX;
  assign hit_chr   = (off >= OFF_CHAR0) && (char_rel < WIN_W'(CH_SPAN)) &&
                     (char_rel[SHIFT-1:0] == '0);
  assign hit_srst  = off == OFF_SOFTRST;
  assign hit_gp    = off == OFF_GPIO;
  assign hit_twin  = off == OFF_TWIN;
  assign hit_twoe  = off == OFF_TWOE;
  assign hit_twout = off == OFF_TWOUT;
  assign hit_twsel = off == OFF_TWSEL;
  assign hit_any   = hit_sw | hit_led | hit_hex | hit_chr | hit_srst | hit_gp |
                     hit_twin | hit_twoe | hit_twout | hit_twsel;

  logic wr, rd;
  assign wr = bus_valid &  bus_we;
  assign rd = bus_valid & ~bus_we;

  logic [LED_W-1:0]  led_q;
  logic [WORD_W-1:0] word_q;
  logic [7:0]        chars_q [NCH];
  logic [7:0]        hex_chr [NCH];
  logic [GP_W-1:0]   gp_q;
  logic [1:0]        oe_q;
  logic              scl_q, sda_q, sel_q, srst_q, twwr_q;

  for (genvar k = 0; k < NCH; k++) begin : g_chr
    assign hex_chr[k]       = hexc(bus_wdata[WORD_W-1-4*k -: 4]);
    assign disp_o[8*k +: 8] = chars_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      led_q  <= '0;
      word_q <= '0;
      gp_q   <= '0;
      oe_q   <= '0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      sel_q  <= 1'b0;
      srst_q <= 1'b0;
      twwr_q <= 1'b0;
      for (int i = 0; i < NCH; i++) chars_q[i] <= 8'h20;
    end else begin
      srst_q <= wr & hit_srst;
      twwr_q <= wr & hit_twout;
      if (wr && hit_led)   led_q  <= bus_wdata[LED_W-1:0];
      if (wr && hit_hex)   word_q <= bus_wdata;
      if (wr && hit_gp)    gp_q   <= bus_wdata[GP_W-1:0];
      if (wr && hit_twoe)  oe_q   <= bus_wdata[1:0];
      if (wr && hit_twsel) sel_q  <= bus_wdata[0];
      if (wr && hit_twout) begin
        scl_q <= bus_wdata[1];
        sda_q <= bus_wdata[0];
      end
      for (int i = 0; i < NCH; i++) begin
        if (wr && hit_hex)
          chars_q[i] <= hex_chr[i];
        else if (wr && hit_chr && char_idx == IDX_W'(i))
          chars_q[i] <= bus_wdata[7:0];
      end
    end
  end

  logic [WORD_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (hit_led)   rd_val = WORD_W'(led_q);
    if (hit_hex)   rd_val = word_q;
    if (hit_chr)   rd_val = WORD_W'(chars_q[char_idx]);
    if (hit_gp)    rd_val = WORD_W'(gp_q);
    if (hit_twin)  rd_val = WORD_W'({scl_q, tw_sda_i});
    if (hit_twoe)  rd_val = WORD_W'(oe_q);
    if (hit_twout) rd_val = WORD_W'({scl_q, sda_q});
    if (hit_twsel) rd_val = WORD_W'(sel_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rdata  <= rd ? rd_val : '0;
      bus_rvalid <= rd;
      bus_err    <= bus_valid & ~hit_any;
    end
  end

  assign led_o      = led_q;
  assign soft_rst_o = srst_q;
  assign gpio_o     = gp_q;
  assign tw_oe_o    = oe_q;
  assign tw_scl_o   = scl_q;
  assign tw_sda_o   = sda_q;
  assign tw_wr_o    = twwr_q;
  assign tw_sel_o   = sel_q;

  assert_soft_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |=> !soft_rst_o);
  assert_soft_src_R6: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |-> $past(bus_valid && bus_we));
  assert_twwr_src_R8: assert property (@(posedge clk) disable iff (rst)
    tw_wr_o |-> $past(bus_valid && bus_we));
  assert_led_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_we) |=> $stable(led_o));
  assert_err_src_R11: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_valid));
  assert_rvalid_src_R12: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_valid && !bus_we));
  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_rvalid |-> bus_rdata == '0);

endmodule

// File: tb/tb_board_ctrl_regs.sv
module tb_board_ctrl_regs;
  logic        clk = 0, rst = 1;
  logic        bus_valid = 0, bus_we = 0, tw_sda_i = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_err, soft_rst_o, tw_scl_o, tw_sda_o, tw_wr_o, tw_sel_o;
  logic [7:0]  led_o, gpio_o;
  logic [63:0] disp_o;
  logic [1:0]  tw_oe_o;

  board_ctrl_regs dut (.*);

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0]  m_led, m_gp;
  logic [7:0]  m_ch [8];
  logic [31:0] m_word, m_rd;
  logic [1:0]  m_oe;
  logic        m_scl, m_sda, m_sel, m_srst, m_twwr, m_rv, m_err;

  function automatic logic [7:0] to_hex(int n);
    return (n < 10) ? 8'(48 + n) : 8'(55 + n);
  endfunction

  function automatic logic [63:0] m_disp();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = m_ch[k];
    return v;
  endfunction

  function automatic int char_slot(int a);
    if (a >= 'h418 && a <= 'h450 && (a % 8) == 0) return (a - 'h418) / 8;
    return -1;
  endfunction

  always @(posedge clk) begin
    int a, s;
    logic known;
    m_srst = 0; m_twwr = 0; m_rv = 0; m_err = 0; m_rd = 0;
    if (rst) begin
      m_led = 0; m_gp = 0; m_word = 0; m_oe = 0; m_scl = 1; m_sda = 1; m_sel = 0;
      for (int k = 0; k < 8; k++) m_ch[k] = 8'h20;
    end else if (bus_valid) begin
      a = int'(bus_addr & 32'hFFFFF);
      s = char_slot(a);
      known = (s >= 0) || a == 'h200 || a == 'h408 || a == 'h410 || a == 'h500 ||
              a == 'hA00 || a == 'hB00 || a == 'hB08 || a == 'hB10 || a == 'hB18;
      if (bus_we) begin
        if (a == 'h408) m_led = bus_wdata[7:0];
        if (a == 'h410) begin
          m_word = bus_wdata;
          for (int k = 0; k < 8; k++) m_ch[k] = to_hex(int'((bus_wdata >> (28 - 4*k)) & 15));
        end
        if (s >= 0) m_ch[s] = bus_wdata[7:0];
        if (a == 'h500) m_srst = 1;
        if (a == 'hA00) m_gp = bus_wdata[7:0];
        if (a == 'hB08) m_oe = bus_wdata[1:0];
        if (a == 'hB18) m_sel = bus_wdata[0];
        if (a == 'hB10) begin m_scl = bus_wdata[1]; m_sda = bus_wdata[0]; m_twwr = 1; end
      end else begin
        m_rv = 1;
        if (a == 'h408) m_rd = {24'h0, m_led};
        if (a == 'h410) m_rd = m_word;
        if (s >= 0)     m_rd = {24'h0, m_ch[s]};
        if (a == 'hA00) m_rd = {24'h0, m_gp};
        if (a == 'hB00) m_rd = {30'h0, m_scl, tw_sda_i};
        if (a == 'hB08) m_rd = {30'h0, m_oe};
        if (a == 'hB10) m_rd = {30'h0, m_scl, m_sda};
        if (a == 'hB18) m_rd = {31'h0, m_sel};
      end
      m_err = !known;
    end
  end

  // compare every clock, after the edge has settled
  always @(posedge clk) begin
    #2;
    chk("R3 led_o", 64'(led_o), 64'(m_led));
    chk("R4 disp_o", disp_o, m_disp());
    chk("R6 soft_rst_o", 64'(soft_rst_o), 64'(m_srst));
    chk("R7 gpio_o", 64'(gpio_o), 64'(m_gp));
    chk("R7 tw_oe_o", 64'(tw_oe_o), 64'(m_oe));
    chk("R7 tw_sel_o", 64'(tw_sel_o), 64'(m_sel));
    chk("R8 scl/sda", 64'({tw_scl_o, tw_sda_o}), 64'({m_scl, m_sda}));
    chk("R8 tw_wr_o", 64'(tw_wr_o), 64'(m_twwr));
    chk("R12 bus_rvalid", 64'(bus_rvalid), 64'(m_rv));
    chk("R12 bus_rdata", 64'(bus_rdata), 64'(m_rd));
    chk("R11 bus_err", 64'(bus_err), 64'(m_err));
  end

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_we = 0;
  endtask

  task automatic rd(logic [31:0] a);
    @(negedge clk); bus_valid = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_valid = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam logic [19:0] PICK [14] = '{20'h00200, 20'h00408, 20'h00410, 20'h00418,
    20'h00430, 20'h00450, 20'h00500, 20'h00A00, 20'h00B00, 20'h00B08, 20'h00B10,
    20'h00B18, 20'h0041C, 20'h00458};

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 reset led", 64'(led_o), 64'h0);
    chk("R10 reset disp", disp_o, {8{8'h20}});
    chk("R10 reset scl/sda", 64'({tw_scl_o, tw_sda_o}), 64'h3);

    rd(32'h0000_0200);
    chk("R2 switch reads zero", 64'(bus_rdata), 64'h0);
    wr(32'h0000_0200, 32'hFFFF_FFFF);
    rd(32'h0000_0200);
    chk("R2 switch after write", 64'(bus_rdata), 64'h0);

    wr(32'h0000_0408, 32'h1234_56A5);
    chk("R3 led low byte", 64'(led_o), 64'hA5);
    wr(32'hFFF0_0408, 32'h0000_003C);
    chk("R1 alias write", 64'(led_o), 64'h3C);
    rd(32'h7AB0_0408);
    chk("R1 alias read", 64'(bus_rdata), 64'h3C);

    wr(32'h0000_0410, 32'hDEAD_BEEF);
    chk("R4 hex DEADBEEF", disp_o, 64'h4645_4542_4441_4544);
    wr(32'h0000_0410, 32'h0123_4567);
    chk("R4 hex digits", disp_o, 64'h3736_3534_3332_3130);
    rd(32'h0000_0410);
    chk("R4 word readback", 64'(bus_rdata), 64'h0123_4567);
    wr(32'h0000_0410, 32'h89AB_CDEF);
    chk("R4 hex letters", disp_o, 64'h4645_4443_4241_3938);

    wr(32'h0000_0450, 32'hFFFF_FF7A);
    chk("R5 char7", 64'(disp_o[63:56]), 64'h7A);
    wr(32'h0000_0418, 32'h0000_0021);
    chk("R5 char0 others kept", disp_o, 64'h7A45_4443_4241_3921);
    rd(32'h0000_0450);
    chk("R5 char7 readback", 64'(bus_rdata), 64'h7A);

    wr(32'h0000_041C, 32'h0000_0055);
    chk("R11 gap write err", 64'(bus_err), 64'h1);
    chk("R11 gap no change", disp_o, 64'h7A45_4443_4241_3921);
    wr(32'h0000_0458, 32'h0000_0055);
    chk("R11 past row no change", disp_o, 64'h7A45_4443_4241_3921);
    rd(32'h0000_0004);
    chk("R11 unmapped read zero", 64'(bus_rdata), 64'h0);
    chk("R11 unmapped read err", 64'(bus_err), 64'h1);

    wr(32'h0000_0500, 32'h0);
    chk("R6 pulse high", 64'(soft_rst_o), 64'h1);
    @(negedge clk);
    chk("R6 pulse one cycle", 64'(soft_rst_o), 64'h0);

    wr(32'h0000_0A00, 32'hFFFF_FF5A);
    wr(32'h0000_0B08, 32'hFFFF_FFFF);
    wr(32'h0000_0B18, 32'h0000_000F);
    chk("R7 gpio", 64'(gpio_o), 64'h5A);
    chk("R7 oe", 64'(tw_oe_o), 64'h3);
    rd(32'h0000_0B18);
    chk("R7 sel readback", 64'(bus_rdata), 64'h1);

    wr(32'h0000_0B10, 32'h0000_0002);
    chk("R8 strobe", 64'(tw_wr_o), 64'h1);
    chk("R8 levels", 64'({tw_scl_o, tw_sda_o}), 64'h2);
    tw_sda_i = 1;
    rd(32'h0000_0B00);
    chk("R9 input sda=1", 64'(bus_rdata), 64'h3);
    wr(32'h0000_0B10, 32'h0000_0001);
    tw_sda_i = 0;
    rd(32'h0000_0B00);
    chk("R9 input sda=0", 64'(bus_rdata), 64'h0);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      a = {$urandom_range(0, 4095) & ((n % 4 == 0) ? 12'hFFF : 12'h000),
           PICK[$urandom_range(0, 13)]};
      tw_sda_i = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 1) == 1) wr(a, $urandom);
      else rd(a);
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R10 mid-run reset disp", disp_o, {8{8'h20}});
    chk("R10 mid-run reset gpio", 64'(gpio_o), 64'h0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule